// File: doc/BRIEF.md
# Six-Pin Shared GPIO Port with Peripheral Takeover

This block is a six-pin bidirectional general-purpose port. Each pin has a data latch bit and a direction bit, both written over a small register bus. Pins can be handed over to on-chip peripherals whenever those peripherals are enabled. A serial peripheral interface uses two pins: its slave data output and its select input. A timer uses two pins, one per channel. An asynchronous serial interface uses a transmit pin and a receive pin.

The block takes the enable and mode signals from these peripherals. It decides who owns each pin and drives the pad output value and output enable. It also passes the synchronised pad inputs to the peripherals. The port read-back path is steered by the direction bit on every pin, including a pin that a peripheral has taken. A firmware-style reader therefore sees either its own latch or the live pin, whoever owns the pin.

Pin map (bit index in every 6-bit port vector): 0 = serial transmit, 1 = serial receive, 2 = timer channel 0, 3 = timer channel 1, 4 = SPI select, 5 = SPI slave data out.

Top module: `gpio_port`

## Requirements
- R1: After reset the latch and direction registers are 0, so with all peripherals disabled every `pad_oe` bit is 0.
- R2: A cycle with `bus_wr`=1 stores `bus_wdata` into the latch when `bus_addr`=0 or into the direction register when `bus_addr`=1. With `bus_addr`=1, `bus_rdata` returns the direction register, bit i for pin i.
- R3: On a pin no peripheral owns, `pad_oe` equals the direction bit and `pad_out` equals the latch bit.
- R4: Pin 5 belongs to the SPI whenever `spi_en`=1. It is then driven (`pad_oe`=1, `pad_out`=`spi_miso_out`) when `spi_master`=0 and is an input when `spi_master`=1. `spi_miso_in` returns the synchronised pin when owned and 0 otherwise.
- R5: Pin 4 belongs to the SPI only when `spi_en`=1 and `spi_master`=0. It is then input-only whatever its direction bit is, and `pad_out` is 0. `spi_ss_in` returns the synchronised pin when owned and 1 otherwise.
- R6: Timer pin 2+c belongs to channel c when its select pair `tim_els[2c+1:2c]` is non-zero. It is then driven by `tim_out[c]` when `tim_oc[c]`=1 and is an input when `tim_oc[c]`=0. `tim_in[c]` returns the synchronised pin when owned and 0 otherwise.
- R7: With `sci_en`=1, pin 0 is always driven by `sci_txd`, and pin 1 is an input with `pad_out` 0. `sci_rxd` returns synchronised pin 1 when owned and 1 otherwise.
- R8: With `bus_addr`=0, bit i of `bus_rdata` is latch bit i when direction bit i is 1, and synchronised pin i when it is 0. This holds whether or not a peripheral owns the pin.
- R9: Latch writes made while a peripheral owns a pin are kept and appear on `pad_out` once the pin is released.
- R10: A change on `pad_in` reaches the read-back path and the peripheral inputs after exactly `SYNC_STAGES` rising edges (default 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = data latch, 1 = direction |
| bus_wdata | input | 6 | Write data |
| bus_rdata | output | 6 | Read data for the selected register |
| pad_in | input | 6 | Pad input levels |
| pad_out | output | 6 | Pad output values |
| pad_oe | output | 6 | Pad output enables |
| spi_en | input | 1 | SPI enabled |
| spi_master | input | 1 | SPI in master mode |
| spi_miso_out | input | 1 | SPI slave data out |
| spi_miso_in | output | 1 | Pin 5 to SPI |
| spi_ss_in | output | 1 | Pin 4 select to SPI |
| tim_els | input | 4 | Edge/level select pair per timer channel |
| tim_oc | input | 2 | 1 = output compare, 0 = input capture |
| tim_out | input | 2 | Timer channel outputs |
| tim_in | output | 2 | Timer channel inputs |
| sci_en | input | 1 | Serial interface enabled |
| sci_txd | input | 1 | Serial transmit data |
| sci_rxd | output | 1 | Serial receive data |

## Verification
A register write and a change of pin ownership can land in the same cycle. An example is a latch or direction write on the edge where an enable or mode input toggles. Random stimulus changes enables, modes and bus writes independently every cycle, so such collisions happen often. Each cycle, bench functions recompute ownership, direction, pad values and read-back from a reference register and synchroniser model, and compare them with every output.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int PORT_W   = 6;
   localparam int TIM_CH   = 2;
   localparam int PIN_TXD  = 0;
   localparam int PIN_RXD  = 1;
   localparam int PIN_TC0  = 2;
   localparam int PIN_SEL  = 4;
   localparam int PIN_SDO  = 5;
   typedef enum logic {REG_DATA = 1'b0, REG_DIR = 1'b1} reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 6,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stage[g] <= '0;
            else        stage[g] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stage[g] <= '0;
            else        stage[g] <= stage[g-1];
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_owner_map.sv
module gpio_owner_map
   import gpio_port_pkg::*;
#(
   parameter int NCH = TIM_CH
) (
   input  logic              spi_en,
   input  logic              spi_master,
   input  logic              spi_miso_out,
   input  logic [2*NCH-1:0]  tim_els,
   input  logic [NCH-1:0]    tim_oc,
   input  logic [NCH-1:0]    tim_out,
   input  logic              sci_en,
   input  logic              sci_txd,
   output logic [PORT_W-1:0] own,
   output logic [PORT_W-1:0] per_oe,
   output logic [PORT_W-1:0] per_out
);
   if (PIN_TC0 + NCH != PIN_SEL) begin : g_bad_map
      $error("timer channels must fill the pins below the select pin");
   end

   for (genvar c = 0; c < NCH; c++) begin : g_tim
      assign own[PIN_TC0+c]     = |tim_els[2*c +: 2];
      assign per_oe[PIN_TC0+c]  = tim_oc[c];
      assign per_out[PIN_TC0+c] = tim_out[c];
   end

   assign own[PIN_SDO]     = spi_en;
   assign per_oe[PIN_SDO]  = ~spi_master;
   assign per_out[PIN_SDO] = spi_miso_out;

   assign own[PIN_SEL]     = spi_en & ~spi_master;
   assign per_oe[PIN_SEL]  = 1'b0;
   assign per_out[PIN_SEL] = 1'b0;

   assign own[PIN_TXD]     = sci_en;
   assign per_oe[PIN_TXD]  = 1'b1;
   assign per_out[PIN_TXD] = sci_txd;

   assign own[PIN_RXD]     = sci_en;
   assign per_oe[PIN_RXD]  = 1'b0;
   assign per_out[PIN_RXD] = 1'b0;
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
   parameter int WIDTH = 6
) (
   input  logic [WIDTH-1:0] own,
   input  logic [WIDTH-1:0] per_oe,
   input  logic [WIDTH-1:0] per_out,
   input  logic [WIDTH-1:0] latch,
   input  logic [WIDTH-1:0] dir,
   input  logic [WIDTH-1:0] pin_s,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] port_rd
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign pad_oe[i]  = own[i] ? per_oe[i]  : dir[i];
      assign pad_out[i] = own[i] ? per_out[i] : latch[i];
      assign port_rd[i] = dir[i] ? latch[i]   : pin_s[i];
   end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_port_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic        bus_addr,
   input  logic [5:0]  bus_wdata,
   output logic [5:0]  bus_rdata,
   input  logic [5:0]  pad_in,
   output logic [5:0]  pad_out,
   output logic [5:0]  pad_oe,
   input  logic        spi_en,
   input  logic        spi_master,
   input  logic        spi_miso_out,
   output logic        spi_miso_in,
   output logic        spi_ss_in,
   input  logic [3:0]  tim_els,
   input  logic [1:0]  tim_oc,
   input  logic [1:0]  tim_out,
   output logic [1:0]  tim_in,
   input  logic        sci_en,
   input  logic        sci_txd,
   output logic        sci_rxd
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [PORT_W-1:0] latch_q, dir_q, pin_s, own, per_oe, per_out, port_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
      end else if (bus_wr) begin
         if (reg_sel_e'(bus_addr) == REG_DIR) dir_q   <= bus_wdata;
         else                                 latch_q <= bus_wdata;
      end
   end

   gpio_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_s));

   gpio_owner_map #(.NCH(TIM_CH)) u_map (
      .spi_en(spi_en), .spi_master(spi_master), .spi_miso_out(spi_miso_out),
      .tim_els(tim_els), .tim_oc(tim_oc), .tim_out(tim_out),
      .sci_en(sci_en), .sci_txd(sci_txd),
      .own(own), .per_oe(per_oe), .per_out(per_out));

   gpio_pin_mux #(.WIDTH(PORT_W)) u_mux (
      .own(own), .per_oe(per_oe), .per_out(per_out),
      .latch(latch_q), .dir(dir_q), .pin_s(pin_s),
      .pad_oe(pad_oe), .pad_out(pad_out), .port_rd(port_rd));

   assign bus_rdata   = (reg_sel_e'(bus_addr) == REG_DIR) ? dir_q : port_rd;
   assign spi_miso_in = own[PIN_SDO] & pin_s[PIN_SDO];
   assign spi_ss_in   = own[PIN_SEL] ? pin_s[PIN_SEL] : 1'b1;
   assign sci_rxd     = own[PIN_RXD] ? pin_s[PIN_RXD] : 1'b1;

   for (genvar c = 0; c < TIM_CH; c++) begin : g_tin
      assign tim_in[c] = own[PIN_TC0+c] & pin_s[PIN_TC0+c];
   end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int SYNC_STAGES = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_wr,
   input logic       bus_addr,
   input logic [5:0] bus_wdata,
   input logic [5:0] bus_rdata,
   input logic [5:0] pad_in,
   input logic [5:0] pad_out,
   input logic [5:0] pad_oe,
   input logic       spi_en,
   input logic       spi_master,
   input logic       spi_miso_out,
   input logic [3:0] tim_els,
   input logic       sci_en,
   input logic       sci_txd,
   input logic       sci_rxd
);
   logic [1:0] warm;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          warm <= '0;
      else if (warm != 2'd3) warm <= warm + 2'd1;

   p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ((!bus_addr || bus_rdata == 6'd0) &&
                        (spi_en || sci_en || (|tim_els) || pad_oe == 6'd0)));

   p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr) |=> (!bus_addr || bus_rdata == $past(bus_wdata)));

   p_sdo_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      spi_en |-> (pad_oe[5] == !spi_master && (spi_master || pad_out[5] == spi_miso_out)));

   p_sel_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_en && !spi_master) |-> !pad_oe[4]);

   p_serial_pins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sci_en |-> (pad_oe[0] && !pad_oe[1] && pad_out[0] == sci_txd));

   if (SYNC_STAGES == 2) begin : g_sync_chk
      p_sync_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (warm >= 2'd2 && sci_en) |-> sci_rxd == $past(pad_in[1], 2));
   end
endmodule

bind gpio_port gpio_port_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
   .pad_out(pad_out), .pad_oe(pad_oe), .spi_en(spi_en),
   .spi_master(spi_master), .spi_miso_out(spi_miso_out),
   .tim_els(tim_els), .sci_en(sci_en), .sci_txd(sci_txd), .sci_rxd(sci_rxd));

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_wr = 0, bus_addr = 0;
   logic [5:0] bus_wdata = 0, bus_rdata, pad_in = 0, pad_out, pad_oe;
   logic spi_en = 0, spi_master = 0, spi_miso_out = 0, spi_miso_in, spi_ss_in;
   logic [3:0] tim_els = 0;
   logic [1:0] tim_oc = 0, tim_out = 0, tim_in;
   logic sci_en = 0, sci_txd = 0, sci_rxd;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [5:0] m_latch = 0, m_dir = 0, m_s1 = 0, m_s2 = 0;

   always #4 clk = ~clk;

   gpio_port dut (.*);

   task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   function automatic logic [5:0] e_own();
      return {spi_en, spi_en & ~spi_master, |tim_els[3:2], |tim_els[1:0], sci_en, sci_en};
   endfunction
   function automatic logic [5:0] e_poe();
      return {~spi_master, 1'b0, tim_oc[1], tim_oc[0], 1'b0, 1'b1};
   endfunction
   function automatic logic [5:0] e_pout();
      return {spi_miso_out, 1'b0, tim_out[1], tim_out[0], 1'b0, sci_txd};
   endfunction
   function automatic string pin_tag(int i, logic o);
      if (!o) return "R3";
      case (i)
         0, 1: return "R7";
         2, 3: return "R6";
         4: return "R5";
         default: return "R4";
      endcase
   endfunction

   task automatic check_all();
      logic [5:0] own = e_own();
      for (int i = 0; i < 6; i++) begin
         chk({pin_tag(i, own[i]), " oe"}, {5'd0, pad_oe[i]},
             {5'd0, own[i] ? e_poe()[i] : m_dir[i]});
         chk({pin_tag(i, own[i]), " out"}, {5'd0, pad_out[i]},
             {5'd0, own[i] ? e_pout()[i] : m_latch[i]});
      end
      if (bus_addr) chk("R2 dir readback", bus_rdata, m_dir);
      else          chk("R8 port readback", bus_rdata, (m_dir & m_latch) | (~m_dir & m_s2));
      chk("R4 sdo in", {5'd0, spi_miso_in}, {5'd0, own[5] & m_s2[5]});
      chk("R5 sel in", {5'd0, spi_ss_in}, {5'd0, own[4] ? m_s2[4] : 1'b1});
      chk("R6 tim in", {4'd0, tim_in}, {4'd0, own[3:2] & m_s2[3:2]});
      chk("R7 rxd", {5'd0, sci_rxd}, {5'd0, own[1] ? m_s2[1] : 1'b1});
   endtask

   // inputs set at negedge; check before posedge; model follows the edge
   task automatic step();
      #2 check_all();
      @(posedge clk);
      if (bus_wr) begin
         if (bus_addr) m_dir = bus_wdata;
         else          m_latch = bus_wdata;
      end
      m_s2 = m_s1;
      m_s1 = pad_in;
      @(negedge clk);
   endtask

   task automatic idle_all();
      bus_wr = 0; spi_en = 0; sci_en = 0; tim_els = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      bus_addr = 1; #1;
      chk("R1 dir after reset", bus_rdata, 6'd0);
      chk("R1 oe after reset", pad_oe, 6'd0);
      rst_n = 1;
      @(negedge clk);
      bus_addr = 0; pad_in = 6'd0;
      repeat (3) step();

      // R10: exact synchroniser delay
      pad_in = 6'h2A;
      step();
      #1 chk("R10 one edge still old", bus_rdata, 6'h00);
      step();
      #1 chk("R10 two edges new", bus_rdata, 6'h2A);

      // R5: direction bit ignored on select pin when slave
      bus_wr = 1; bus_addr = 1; bus_wdata = 6'h3F; step();
      bus_wr = 0; spi_en = 1; spi_master = 0; #1;
      chk("R5 sel oe forced input", {5'd0, pad_oe[4]}, 6'd0);
      step();

      // R9/R8: latch write while serial owns pins
      idle_all(); sci_en = 1; sci_txd = 0;
      bus_wr = 1; bus_addr = 0; bus_wdata = 6'h01; step();
      bus_wr = 0; #1;
      chk("R9 owned tx ignores latch", {5'd0, pad_out[0]}, 6'd0);
      chk("R8 readback of latch while owned", {5'd0, bus_rdata[0]}, 6'd1);
      step();
      sci_en = 0; #1;
      chk("R9 released tx shows latch", {5'd0, pad_out[0]}, 6'd1);
      step();

      // random mix
      for (int n = 0; n < 3000; n++) begin
         bus_wr = $urandom_range(0, 1); bus_addr = $urandom_range(0, 1);
         bus_wdata = 6'($urandom); pad_in = 6'($urandom);
         spi_en = $urandom_range(0, 1); spi_master = $urandom_range(0, 1);
         spi_miso_out = $urandom_range(0, 1);
         tim_els = 4'($urandom); tim_oc = 2'($urandom); tim_out = 2'($urandom);
         sci_en = $urandom_range(0, 1); sci_txd = $urandom_range(0, 1);
         step();
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule